// File: doc/BRIEF.md
# Delta-Modulation Sample Voice

This block is the one-bit delta-modulation voice of a sound unit. It reads a stream of sample bytes from memory, one byte per request, and turns every bit into a step of plus or minus two on a 7-bit output level. Bits are taken most significant first. A step that would leave the range 0 to 127 is dropped and the level stays where it was.

Software programs four registers and a channel-enable bit through a single byte-wide write port. The registers set the playback rate and flags, the output level, the sample start address and the sample length. The voice advances only in cycles where the CPU-cycle enable is high. When a sample ends, the voice either restarts it, if looping is set, or stops and raises an interrupt flag, if interrupts are enabled. Writing the enable bit restarts a finished sample or cuts off a running one. An output reports whether any bytes are left to fetch.

Top module: `dmc_voice`

## Requirements
- R1: After reset the level is 0, irq is 0, active is 0 and fetch_req is 0.
- R2: A write with wr_sel=1 sets the level to wr_data[6:0] in the next cycle.
- R3: A write with wr_sel=0 stores bit 7 as interrupt enable, bit 6 as loop, and bits 3:0 as a rate index. The index selects a period P from 428,380,340,320,286,254,226,214,190,160,142,128,106,84,72,54 enabled cycles per bit. With cpu_en held high and each byte returned in the cycle after its request rises, consecutive requests start 8*P+1 cycles apart.
- R4: A write with wr_sel=2 of value A sets the start address to {2'b11,A,6'b000000}. Fetches read the current address with bit 15 forced to 1. The address then advances by one and wraps at 16 bits.
- R5: A sample is L*16+1 bytes long, where L is the value written with wr_sel=3. A length write reloads the remaining count only when that count is zero.
- R6: Each bit moves the level by +2 for a 1 or -2 for a 0, most significant bit first. A step whose result falls outside 0..127 is skipped.
- R7: When the bit buffer is empty at a bit period, the count is zero and loop is clear, the voice stops fetching. It sets irq if interrupt enable is set.
- R8: With loop set, a zero count at an empty bit buffer reloads both the start address and the length, and playback continues.
- R9: irq is cleared by a rate write with bit 7 clear and by any enable write.
- R10: A write with wr_sel=4 and bit 0 clear zeroes the count (active is low in the next cycle) and halts the voice. With bit 0 set and a zero count, it reloads the count and the start address and empties the bit buffer.
- R11: fetch_req stays high with a stable fetch_addr until fetch_valid. Bit processing and the period timer wait while a request is open.
- R12: active is high exactly when the remaining byte count is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_en | input | 1 | One-cycle advance enable for the period timer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 rate/flags, 1 level, 2 start, 3 length, 4 enable |
| wr_data | input | 8 | Write data |
| fetch_req | output | 1 | Byte fetch request |
| fetch_addr | output | 16 | Fetch address, bit 15 always set |
| fetch_valid | input | 1 | Fetched byte present on fetch_data |
| fetch_data | input | 8 | Fetched byte |
| level | output | 7 | Current output level |
| active | output | 1 | Remaining byte count is nonzero |
| irq | output | 1 | End-of-sample interrupt flag |

## Verification
The assertions assume that memory raises fetch_valid only while fetch_req is high and presents the byte in that same cycle. They also assume that writes arrive as single-cycle strobes. The bench's memory responder answers only an open request, after a random delay of zero to two cycles, and it drops valid in the cycle after. All register traffic passes through a one-cycle write task, and cpu_en is randomised only in the runs that check order and final level, not timing.

// File: rtl/dmc_voice.sv
module dmc_voice (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_en,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [7:0]  wr_data,
  output logic        fetch_req,
  output logic [15:0] fetch_addr,
  input  logic        fetch_valid,
  input  logic [7:0]  fetch_data,
  output logic [6:0]  level,
  output logic        active,
  output logic        irq
);
  localparam logic [2:0] SEL_RATE = 3'd0;
  localparam logic [2:0] SEL_LVL  = 3'd1;
  localparam logic [2:0] SEL_ADR  = 3'd2;
  localparam logic [2:0] SEL_LEN  = 3'd3;
  localparam logic [2:0] SEL_EN   = 3'd4;

  logic        irq_en, loop_en, en;
  logic [3:0]  rate_idx;
  logic [7:0]  start_a, len_l;
  logic [11:0] cnt;
  logic [15:0] addr;
  logic [7:0]  shreg;
  logic [3:0]  bits;
  logic [8:0]  timer, reload;

  always_comb begin
    case (rate_idx)
      4'd0:  reload = 9'd427;
      4'd1:  reload = 9'd379;
      4'd2:  reload = 9'd339;
      4'd3:  reload = 9'd319;
      4'd4:  reload = 9'd285;
      4'd5:  reload = 9'd253;
      4'd6:  reload = 9'd225;
      4'd7:  reload = 9'd213;
      4'd8:  reload = 9'd189;
      4'd9:  reload = 9'd159;
      4'd10: reload = 9'd141;
      4'd11: reload = 9'd127;
      4'd12: reload = 9'd105;
      4'd13: reload = 9'd83;
      4'd14: reload = 9'd71;
      default: reload = 9'd53;
    endcase
  end

  wire [15:0] start_addr = {2'b11, start_a, 6'b000000};
  wire [11:0] len_total  = {len_l, 4'b0000} + 12'd1;
  wire        run        = cpu_en && en && !fetch_req && (reload != 9'd0);
  wire        tick       = run && (timer == 9'd0);
  wire        need_rl    = (cnt == 12'd0) && loop_en;
  wire [11:0] cnt_eff    = need_rl ? len_total : cnt;
  wire [15:0] addr_eff   = need_rl ? start_addr : addr;
  wire        got        = fetch_req && fetch_valid;
  wire        step_bit   = got ? fetch_data[7] : shreg[7];
  wire        do_step    = got || (tick && bits != 4'd0);
  wire [7:0]  stepped    = step_bit ? {1'b0, level} + 8'd2 : {1'b0, level} - 8'd2;

  assign active = (cnt != 12'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0; loop_en <= 1'b0; en <= 1'b0; rate_idx <= 4'd0;
      start_a <= 8'd0; len_l <= 8'd0; cnt <= 12'd0; addr <= 16'd0;
      shreg <= 8'd0; bits <= 4'd0; timer <= 9'd0; level <= 7'd0;
      fetch_req <= 1'b0; fetch_addr <= 16'h8000; irq <= 1'b0;
    end else begin
      if (run) timer <= (timer == 9'd0) ? reload : timer - 9'd1;

      if (tick) begin
        if (bits == 4'd0) begin
          if (need_rl) begin
            cnt  <= len_total;
            addr <= start_addr;
          end
          if (cnt_eff != 12'd0) begin
            fetch_req  <= 1'b1;
            fetch_addr <= addr_eff | 16'h8000;
          end else begin
            en <= 1'b0;
            if (irq_en) irq <= 1'b1;
          end
        end else begin
          bits  <= bits - 4'd1;
          shreg <= {shreg[6:0], 1'b0};
        end
      end

      if (got) begin
        fetch_req <= 1'b0;
        shreg     <= {fetch_data[6:0], 1'b0};
        bits      <= 4'd7;
        addr      <= addr + 16'd1;
        if (cnt != 12'd0) cnt <= cnt - 12'd1;
      end

      if (do_step && !stepped[7]) level <= stepped[6:0];

      if (wr_en) begin
        case (wr_sel)
          SEL_RATE: begin
            irq_en   <= wr_data[7];
            loop_en  <= wr_data[6];
            rate_idx <= wr_data[3:0];
            if (!wr_data[7]) irq <= 1'b0;
          end
          SEL_LVL: level <= wr_data[6:0];
          SEL_ADR: begin
            start_a <= wr_data;
            addr    <= {2'b11, wr_data, 6'b000000};
          end
          SEL_LEN: begin
            len_l <= wr_data;
            if (cnt == 12'd0) cnt <= {wr_data, 4'b0000} + 12'd1;
          end
          SEL_EN: begin
            en  <= wr_data[0];
            irq <= 1'b0;
            if (!wr_data[0]) cnt <= 12'd0;
            else if (cnt == 12'd0) begin
              cnt  <= len_total;
              addr <= start_addr;
              bits <= 4'd0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmc_voice_chk.sv
module dmc_voice_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [7:0]  wr_data,
  input logic        fetch_req,
  input logic [15:0] fetch_addr,
  input logic        fetch_valid,
  input logic [6:0]  level,
  input logic        active,
  input logic        irq
);
  AST_FETCH_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> fetch_addr[15]); // R4

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !fetch_valid |=> fetch_req && $stable(fetch_addr)); // R11

  AST_LEVEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 3'd1 |=> level == $past(wr_data[6:0])); // R2

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 3'd1) |=> (level == $past(level)) ||
      ({1'b0, level} == {1'b0, $past(level)} + 8'd2) ||
      ({1'b0, level} + 8'd2 == {1'b0, $past(level)})); // R6

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_sel == 3'd4 || (wr_sel == 3'd0 && !wr_data[7])) |=> !irq); // R9

  AST_STOP_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 3'd4 && !wr_data[0] |=> !active); // R10
endmodule

bind dmc_voice dmc_voice_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
  .level(level), .active(active), .irq(irq)
);

// File: tb/dmc_voice_tb_top.sv
`timescale 1ns/1ps
module dmc_voice_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cpu_en = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic fetch_req, fetch_valid = 1'b0;
  logic [15:0] fetch_addr;
  logic [7:0] fetch_data = 8'd0;
  logic [6:0] level;
  logic active, irq;

  int total = 0, bad = 0, cyc = 0, fetch_n = 0;
  bit rnd_en = 0, rnd_dly = 0, force_on = 0;
  logic [7:0] force_byte = 8'd0, salt = 8'd0;
  logic [15:0] log_addr [0:127];
  logic [7:0]  log_data [0:127];
  int          log_cyc  [0:127];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dmc_voice dut_i (.clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .level(level),
    .active(active), .irq(irq));

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return force_on ? force_byte : ((a[7:0] * 8'd29) ^ a[15:8] ^ salt);
  endfunction

  function automatic logic [6:0] exp_level(input logic [6:0] l0, input int n);
    int l = l0;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        int t = log_data[i][b] ? l + 2 : l - 2;
        if (t >= 0 && t <= 127) l = t;
      end
    return 7'(l);
  endfunction

  function automatic int period(input int idx);
    case (idx)
      0: return 428; 1: return 380; 2: return 340; 3: return 320;
      4: return 286; 5: return 254; 6: return 226; 7: return 214;
      8: return 190; 9: return 160; 10: return 142; 11: return 128;
      12: return 106; 13: return 84; 14: return 72; default: return 54;
    endcase
  endfunction

  initial forever begin
    @(negedge clk);
    cpu_en = rnd_en ? ($urandom % 4 != 0) : 1'b1;
  end

  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (fetch_valid) fetch_valid = 1'b0;
      else if (fetch_req) begin
        if (dly == 0) begin
          fetch_valid = 1'b1;
          fetch_data = mem_byte(fetch_addr);
          if (fetch_n < 128) begin
            log_addr[fetch_n] = fetch_addr;
            log_data[fetch_n] = fetch_data;
            log_cyc[fetch_n] = cyc;
          end
          fetch_n++;
          dly = rnd_dly ? int'($urandom % 3) : 0;
        end else dly--;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_addrs(input logic [7:0] a, input int n, input string req);
    int miss = 0;
    logic [15:0] e;
    for (int i = 0; i < n && i < 128; i++) begin
      e = (16'({2'b11, a, 6'b000000}) + 16'(i)) | 16'h8000;
      if (log_addr[i] !== e) miss++;
    end
    chk(miss == 0, req, miss, 0);
  endtask

  task automatic play(input logic [7:0] a, input logic [7:0] l, input logic [7:0] rate,
                      input logic [6:0] l0, input bit mid_len, input bit clr_rate);
    int g = 0;
    wr(3'd0, rate); wr(3'd1, {1'b0, l0}); wr(3'd2, a);
    fetch_n = 0;
    wr(3'd3, l); wr(3'd4, 8'h01);
    if (mid_len) begin
      while (fetch_n < 3) @(negedge clk);
      wr(3'd3, 8'd9); // R5 length write while count nonzero
    end
    while (!irq && g < 80000) begin @(negedge clk); g++; end
    chk(irq === 1'b1, "R7 irq at end", irq, 1);
    chk(fetch_n == l * 16 + 1, "R5 byte count", fetch_n, l * 16 + 1);
    check_addrs(a, fetch_n, "R4 address sequence");
    chk(level == exp_level(l0, fetch_n), "R6 final level", level, exp_level(l0, fetch_n));
    chk(active === 1'b0, "R12 active low when drained", active, 0);
    if (clr_rate) wr(3'd0, 8'h0F); else wr(3'd4, 8'h00);
    chk(irq === 1'b0, "R9 irq cleared", irq, 0);
  endtask

  task automatic rate_run(input int idx);
    int p = period(idx);
    int n;
    wr(3'd0, 8'h40 | 8'(idx)); wr(3'd1, 8'd64); wr(3'd2, 8'h12);
    fetch_n = 0;
    wr(3'd3, 8'd0); wr(3'd4, 8'h01);
    while (fetch_n < 2) @(negedge clk);
    chk(log_cyc[1] - log_cyc[0] == 8 * p + 1, "R3 bit period", log_cyc[1] - log_cyc[0], 8 * p + 1);
    chk(log_addr[1] == 16'hC480 && log_addr[0] == 16'hC480, "R8 loop reload address",
        log_addr[1], 16'hC480);
    wr(3'd4, 8'h00);
    chk(active === 1'b0, "R10 enable clear zeroes count", active, 0);
    wait_cycles(2);
    n = fetch_n;
    wait_cycles(10 * p);
    chk(fetch_n == n, "R10 no fetch after disable", fetch_n, n);
    chk(irq === 1'b0, "R7 no irq when disabled", irq, 0);
    fetch_n = 0;
    wr(3'd4, 8'h01);
    chk(active === 1'b1, "R10 enable set reloads count", active, 1);
    while (fetch_n < 1) @(negedge clk);
    chk(log_addr[0] == 16'hC480, "R10 enable set reloads address", log_addr[0], 16'hC480);
    wr(3'd4, 8'h00);
    wait_cycles(3);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    wait_cycles(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(level == 7'd0 && irq === 1'b0 && active === 1'b0 && fetch_req === 1'b0,
        "R1 reset state", {level, irq, active, fetch_req}, 0);

    wr(3'd1, 8'hFF);
    chk(level == 7'd127, "R2 level write masked", level, 127);
    wr(3'd1, 8'h35);
    chk(level == 7'h35, "R2 level write", level, 8'h35);

    rate_run(0);
    rate_run(15);

    force_on = 1; force_byte = 8'h00;
    play(8'h20, 8'd0, 8'h8F, 7'd1, 0, 0);   // R6 low clamp
    force_byte = 8'hFF;
    play(8'h21, 8'd0, 8'h8F, 7'd126, 0, 1); // R6 high clamp, R9 rate clear
    force_byte = 8'hA5;
    play(8'h22, 8'd0, 8'h8F, 7'd64, 0, 0);
    force_on = 0;

    play(8'hFF, 8'd4, 8'h8F, 7'd40, 0, 0);  // R4 wrap to 0x8000
    play(8'h33, 8'd1, 8'h8E, 7'd90, 1, 0);  // R5 mid length write

    wr(3'd0, 8'h0F); wr(3'd1, 8'd20); wr(3'd2, 8'h44);
    fetch_n = 0;
    wr(3'd3, 8'd0); wr(3'd4, 8'h01);
    wait_cycles(1500);
    chk(irq === 1'b0, "R7 irq off stays low", irq, 0);
    chk(fetch_n == 1, "R7 single byte then stop", fetch_n, 1);
    chk(level == exp_level(7'd20, 1), "R6 level irq-off run", level, exp_level(7'd20, 1));

    rnd_en = 1; rnd_dly = 1;
    for (int k = 0; k < 4; k++) begin
      salt = 8'($urandom);
      play(8'($urandom), 8'($urandom % 2), 8'h8E | 8'($urandom % 2),
           7'($urandom), 0, k[0]); // R11 random stalls
    end
    rnd_en = 0; rnd_dly = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule